// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This block multiplies two 16-bit operands and combines the product with a 40-bit accumulator. Each operand is marked signed or unsigned on its own, so all four signedness pairings are available for building wider products. The product is sign-extended to 40 bits. In fractional mode it is also moved up one place with a zero entering the LSB, which aligns a 1.15 by 1.15 product as 1.31. An operation then loads the aligned product into the accumulator, adds it to the accumulator, or subtracts it from the accumulator.

Further operations clear the accumulator, round it at the boundary between bits 15 and 16, or clamp it to the 32-bit signed range on explicit command. The 8 guard bits let long sums pass through out-of-range intermediate values without wrapping. An overflow flag shows whether the top nine accumulator bits disagree. A 16-bit feedback register can take bits 31:16 of a product or rounded result in place of the accumulator. Software-visible writes load the three accumulator sections (16, 16 and 8 bits), and the top section is also presented sign-extended to 16 bits.

Top module: `mac40_unit`

## Requirements
- R1: After reset the accumulator, the feedback register and the overflow flag are all zero.
- R2: `op_i`=1 (load) places the product in the accumulator. Each operand is taken as two's complement when its own signed input is 1 and as unsigned when it is 0, and the product is sign-extended to 40 bits.
- R3: With `frac_i`=1 the sign-extended product is shifted left by one with a zero LSB before use. With `frac_i`=0 it is not shifted.
- R4: `op_i`=2 adds the aligned product to the accumulator and `op_i`=3 subtracts it, both modulo 2^40.
- R5: Every operation with `op_i` from 1 to 6 sets the overflow flag to 1 exactly when bits 39:31 of its result are not all equal. `op_i`=0 or 7 and section writes leave the flag unchanged.
- R6: `op_i`=5 (saturate) leaves the accumulator unchanged when the flag is 0. When the flag is 1 it loads 0x007FFFFFFF if bit 39 is 0 and 0xFF80000000 if bit 39 is 1.
- R7: `op_i`=6 (round) with `bias_i`=0 adds 0x8000 to the accumulator. If the low 16 bits were exactly 0x8000, bit 16 of the sum is then forced to 0.
- R8: Round with `bias_i`=1 adds 0x8000 and never forces bit 16. Values whose low half is not 0x8000 give the same result as in R7.
- R9: With `to_fb_i`=1, load, add, subtract and round write bits 31:16 of their result to the feedback register and leave the accumulator unchanged. Clear and saturate always target the accumulator.
- R10: `wr_en_i` with `wr_sel_i`=0 writes bits 15:0 and leaves 39:16 alone. `wr_sel_i`=1 writes bits 31:16 and fills bits 39:32 with bit 15 of the data. `wr_sel_i`=2 writes bits 39:32 from data bits 7:0. `wr_sel_i`=3 has no effect.
- R11: `top_o` is accumulator bits 39:32 sign-extended to 16 bits.
- R12: When a section write and an operation fall in the same cycle, the write alone sets the accumulator. The operation reads the accumulator value from before the write and still updates the flag and, if it targets it, the feedback register.
- R13: `op_i`=4 (clear) sets the accumulator to zero and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | 0 none, 1 load, 2 add, 3 subtract, 4 clear, 5 saturate, 6 round, 7 none |
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand |
| x_signed_i | input | 1 | First operand is two's complement |
| y_signed_i | input | 1 | Second operand is two's complement |
| frac_i | input | 1 | Fractional alignment of the product |
| to_fb_i | input | 1 | Result goes to the feedback register |
| bias_i | input | 1 | Biased rounding |
| wr_en_i | input | 1 | Section write strobe |
| wr_sel_i | input | 2 | Section: 0 low, 1 middle, 2 top, 3 none |
| wr_data_i | input | 16 | Section write data |
| acc_o | output | 40 | Accumulator |
| top_o | output | 16 | Top section sign-extended |
| fb_o | output | 16 | Feedback register |
| ovf_o | output | 1 | Overflow flag |

## Verification
A section write and an arithmetic operation can fall in the same clock edge. The bench provokes this by issuing writes to each section together with add, round and clear operations, once with the result aimed at the accumulator and once with it aimed at the feedback register. The bench judges each case against its model: the accumulator must show only the written section, while the flag and feedback register must reflect the operation computed from the accumulator value before the write. Saturation is provoked on both signs immediately after overflowing loads and subtractions.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
    localparam int OP_W   = 16;
    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + 8;
    localparam int GUARD  = ACC_W - PROD_W;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_CLR   = 3'd4,
        OP_SAT   = 3'd5,
        OP_RND   = 3'd6,
        OP_NONE2 = 3'd7
    } mac_op_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OP_W-1:0]  fb;
        logic             ovf;
    } mac_state_t;

    function automatic logic out_of_range(input logic [ACC_W-1:0] v);
        return !((&v[ACC_W-1:PROD_W-1]) || !(|v[ACC_W-1:PROD_W-1]));
    endfunction
endpackage

// File: rtl/mac40_product.sv
module mac40_product
    import mac40_pkg::*;
(
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  logic             a_sgn_i,
    input  logic             b_sgn_i,
    input  logic             frac_i,
    output logic [ACC_W-1:0] p_o
);
    localparam int EXT_W = OP_W + 1;
    localparam int RAW_W = 2 * EXT_W;

    logic signed [EXT_W-1:0] a_ext, b_ext;
    logic signed [RAW_W-1:0] raw;
    logic        [ACC_W-1:0] wide;

    always_comb begin
        a_ext = $signed({a_sgn_i & a_i[OP_W-1], a_i});
        b_ext = $signed({b_sgn_i & b_i[OP_W-1], b_i});
        raw   = a_ext * b_ext;
        wide  = {{(ACC_W-RAW_W){raw[RAW_W-1]}}, raw};
        p_o   = frac_i ? {wide[ACC_W-2:0], 1'b0} : wide;
    end
endmodule

// File: rtl/mac40_round.sv
module mac40_round
    import mac40_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic             bias_i,
    output logic [ACC_W-1:0] r_o
);
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (OP_W - 1);

    logic tie;
    logic [ACC_W-1:0] sum;

    always_comb begin
        tie = (acc_i[OP_W-1:0] == HALF[OP_W-1:0]);
        sum = acc_i + HALF;
        r_o = sum;
        if (tie && !bias_i) begin
            r_o[OP_W] = 1'b0;
        end
    end
endmodule

// File: rtl/mac40_sat.sv
module mac40_sat
    import mac40_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic             ovf_i,
    output logic [ACC_W-1:0] s_o
);
    localparam logic [ACC_W-1:0] POS_MAX = {{(GUARD+1){1'b0}}, {(PROD_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MAX = {{(GUARD+1){1'b1}}, {(PROD_W-1){1'b0}}};

    always_comb begin
        if (!ovf_i) begin
            s_o = acc_i;
        end else if (acc_i[ACC_W-1]) begin
            s_o = NEG_MAX;
        end else begin
            s_o = POS_MAX;
        end
    end
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
    import mac40_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [OP_W-1:0]   x_i,
    input  logic [OP_W-1:0]   y_i,
    input  logic              x_signed_i,
    input  logic              y_signed_i,
    input  logic              frac_i,
    input  logic              to_fb_i,
    input  logic              bias_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [OP_W-1:0]   wr_data_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [OP_W-1:0]   top_o,
    output logic [OP_W-1:0]   fb_o,
    output logic              ovf_o
);
    mac_state_t state_q, state_d;
    logic [ACC_W-1:0] prod_w, rnd_w, sat_w, res_w;
    logic res_en, res_to_fb, wr_hit;

    mac40_product u_prod (
        .a_i    (x_i),
        .b_i    (y_i),
        .a_sgn_i(x_signed_i),
        .b_sgn_i(y_signed_i),
        .frac_i (frac_i),
        .p_o    (prod_w)
    );

    mac40_round u_rnd (
        .acc_i (state_q.acc),
        .bias_i(bias_i),
        .r_o   (rnd_w)
    );

    mac40_sat u_sat (
        .acc_i(state_q.acc),
        .ovf_i(state_q.ovf),
        .s_o  (sat_w)
    );

    always_comb begin
        state_d   = state_q;
        res_w     = state_q.acc;
        res_en    = 1'b0;
        res_to_fb = 1'b0;
        wr_hit    = wr_en_i && (wr_sel_i != 2'd3);

        case (mac_op_e'(op_i))
            OP_LOAD: begin res_w = prod_w;               res_en = 1'b1; res_to_fb = to_fb_i; end
            OP_ADD:  begin res_w = state_q.acc + prod_w; res_en = 1'b1; res_to_fb = to_fb_i; end
            OP_SUB:  begin res_w = state_q.acc - prod_w; res_en = 1'b1; res_to_fb = to_fb_i; end
            OP_CLR:  begin res_w = '0;                   res_en = 1'b1; end
            OP_SAT:  begin res_w = sat_w;                res_en = 1'b1; end
            OP_RND:  begin res_w = rnd_w;                res_en = 1'b1; res_to_fb = to_fb_i; end
            default: begin res_en = 1'b0; end
        endcase

        if (res_en) begin
            state_d.ovf = out_of_range(res_w);
            if (res_to_fb) begin
                state_d.fb = res_w[PROD_W-1:OP_W];
            end else if (!wr_hit) begin
                state_d.acc = res_w;
            end
        end

        if (wr_hit) begin
            state_d.acc = state_q.acc;
            case (wr_sel_i)
                2'd0: state_d.acc[OP_W-1:0] = wr_data_i;
                2'd1: begin
                    state_d.acc[PROD_W-1:OP_W]  = wr_data_i;
                    state_d.acc[ACC_W-1:PROD_W] = {GUARD{wr_data_i[OP_W-1]}};
                end
                default: state_d.acc[ACC_W-1:PROD_W] = wr_data_i[GUARD-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o = state_q.acc;
    assign fb_o  = state_q.fb;
    assign ovf_o = state_q.ovf;
    assign top_o = {{(OP_W-GUARD){state_q.acc[ACC_W-1]}}, state_q.acc[ACC_W-1:PROD_W]};
endmodule

// File: rtl/mac40_unit_chk.sv
module mac40_unit_chk
    import mac40_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic              to_fb_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [OP_W-1:0]   wr_data_i,
    input logic [ACC_W-1:0]  acc_o,
    input logic [OP_W-1:0]   top_o,
    input logic              ovf_o
);
    logic quiet_wr;
    assign quiet_wr = !wr_en_i || (wr_sel_i == 2'd3);

    assert_clear_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 && quiet_wr) |=> (acc_o == '0 && !ovf_o));

    assert_add_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && !to_fb_i && quiet_wr) |=>
        (ovf_o == !((&acc_o[ACC_W-1:PROD_W-1]) || !(|acc_o[ACC_W-1:PROD_W-1]))));

    assert_idle_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd7) |=> $stable(ovf_o));

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && !ovf_o && quiet_wr) |=> $stable(acc_o));

    assert_fb_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (to_fb_i && (op_i == 3'd1 || op_i == 3'd6) && quiet_wr) |=> $stable(acc_o));

    assert_mid_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd1) |=>
        (acc_o[PROD_W-1:OP_W] == $past(wr_data_i) &&
         acc_o[ACC_W-1:PROD_W] == {GUARD{$past(wr_data_i[OP_W-1])}}));

    assert_top_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
        top_o[OP_W-1:GUARD] == {(OP_W-GUARD){acc_o[ACC_W-1]}});
endmodule

bind mac40_unit mac40_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .to_fb_i  (to_fb_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .acc_o    (acc_o),
    .top_o    (top_o),
    .ovf_o    (ovf_o)
);

// File: tb/mac40_unit_bench.sv
module mac40_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] x = '0, y = '0, wd = '0;
    logic xs = 1'b0, ys = 1'b0, frac = 1'b0, tofb = 1'b0, bias = 1'b0, we = 1'b0;
    logic [1:0]  wsel = 2'd0;
    logic [39:0] acc;
    logic [15:0] top, fb;
    logic        ovf;

    logic [39:0] m_acc = '0;
    logic [15:0] m_fb = '0;
    logic        m_ovf = 1'b0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mac40_unit u_mac40_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .x_i(x), .y_i(y),
        .x_signed_i(xs), .y_signed_i(ys), .frac_i(frac), .to_fb_i(tofb),
        .bias_i(bias), .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wd),
        .acc_o(acc), .top_o(top), .fb_o(fb), .ovf_o(ovf)
    );

    function automatic logic [39:0] ref_prod(input logic [15:0] a, input logic [15:0] b,
                                             input logic as, input logic bs, input logic f);
        longint va = as ? longint'($signed(a)) : longint'(a);
        longint vb = bs ? longint'($signed(b)) : longint'(b);
        longint p = va * vb;
        if (f) p = p * 2;
        return p[39:0];
    endfunction

    function automatic logic ref_ovf(input logic [39:0] r);
        longint s = longint'($signed(r));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic logic [39:0] ref_round(input logic [39:0] a, input logic b);
        logic [39:0] r = a + 40'h8000;
        if (a[15:0] == 16'h8000 && !b) r = r & ~(40'h1 << 16);
        return r;
    endfunction

    task automatic model_step();
        logic [39:0] r = m_acc;
        logic valid = 1'b1;
        logic fbt = 1'b0;
        logic [39:0] p = ref_prod(x, y, xs, ys, frac);
        logic [39:0] old = m_acc;
        case (op)
            3'd1: begin r = p; fbt = tofb; end
            3'd2: begin r = old + p; fbt = tofb; end
            3'd3: begin r = old - p; fbt = tofb; end
            3'd4: r = '0;
            3'd5: r = !m_ovf ? old : (old[39] ? 40'hFF80000000 : 40'h007FFFFFFF);
            3'd6: begin r = ref_round(old, bias); fbt = tofb; end
            default: valid = 1'b0;
        endcase
        if (valid) begin
            m_ovf = ref_ovf(r);
            if (fbt) m_fb = r[31:16];
            else m_acc = r;
        end
        if (we && wsel != 2'd3) begin
            m_acc = old;
            if (wsel == 2'd0) m_acc[15:0] = wd;
            else if (wsel == 2'd1) m_acc = {{8{wd[15]}}, wd, old[15:0]};
            else m_acc[39:32] = wd[7:0];
        end
    endtask

    task automatic compare(input string tag);
        logic [15:0] m_top = {{8{m_acc[39]}}, m_acc[39:32]};
        checks++;
        if (acc !== m_acc || top !== m_top || fb !== m_fb || ovf !== m_ovf) begin
            fails++;
            $display("FAIL %s: acc=%h top=%h fb=%h ovf=%b expected acc=%h top=%h fb=%h ovf=%b",
                     tag, acc, top, fb, ovf, m_acc, m_top, m_fb, m_ovf);
        end
    endtask

    task automatic expect_acc(input logic [39:0] v, input string tag);
        checks++;
        if (acc !== v) begin
            fails++;
            $display("FAIL %s: acc=%h expected %h", tag, acc, v);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                        input logic as, input logic bs, input logic f, input logic t,
                        input logic bi, input logic w, input logic [1:0] s,
                        input logic [15:0] d, input string tag);
        op = o; x = a; y = b; xs = as; ys = bs; frac = f; tofb = t; bias = bi;
        we = w; wsel = s; wd = d;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d, input string tag);
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, 1, s, d, tag);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        expect_acc(40'h0, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 signedness pairings, integer alignment
        step(3'd1, 16'hFFFD, 16'd5, 1, 1, 0, 0, 0, 0, 0, 0, "R2 ss");
        expect_acc(40'hFFFFFFFFF1, "R2 ss value");
        step(3'd1, 16'hFFFD, 16'd5, 0, 1, 0, 0, 0, 0, 0, 0, "R2 us");
        expect_acc(40'h000004FFF1, "R2 us value");
        step(3'd1, 16'hFFFD, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 0, "R2 su");
        step(3'd1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R2 uu");
        expect_acc(40'h00FFFE0001, "R2 uu value");

        // R3 fractional alignment
        step(3'd1, 16'h4000, 16'h4000, 1, 1, 1, 0, 0, 0, 0, 0, "R3 frac");
        expect_acc(40'h0020000000, "R3 frac value");
        step(3'd1, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 0, 0, 0, "R3 R5 frac overflow");
        expect_acc(40'h0080000000, "R3 corner value");

        // R6 saturate positive, then hold
        step(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 sat pos");
        expect_acc(40'h007FFFFFFF, "R6 sat pos value");
        step(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 sat no ovf hold");

        // R13 clear, R4 subtract to negative limit and beyond, R6 saturate negative
        step(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R13 clear");
        step(3'd3, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 0, 0, 0, "R4 sub");
        expect_acc(40'hFF80000000, "R4 sub value");
        step(3'd3, 16'd1, 16'd1, 1, 1, 0, 0, 0, 0, 0, 0, "R4 R5 sub overflow");
        step(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 sat neg");
        expect_acc(40'hFF80000000, "R6 sat neg value");

        // R7 R8 rounding ties and non-ties
        wr(2'd1, 16'h0000, "R10 mid");
        wr(2'd0, 16'h8000, "R10 low");
        step(3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 even tie");
        expect_acc(40'h0000000000, "R7 even tie value");
        wr(2'd0, 16'h8000, "R10 low");
        step(3'd6, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 biased tie");
        expect_acc(40'h0000010000, "R8 biased tie value");
        wr(2'd0, 16'h8000, "R10 low");
        step(3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 odd tie");
        expect_acc(40'h0000020000, "R7 odd tie value");
        wr(2'd0, 16'h7FFF, "R10 low");
        step(3'd6, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 below tie");
        wr(2'd0, 16'h8001, "R10 low");
        step(3'd6, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 above tie");

        // R9 feedback target
        step(3'd6, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 round to fb");
        step(3'd1, 16'h1234, 16'h0100, 1, 1, 0, 1, 0, 0, 0, 0, "R9 load to fb");
        step(3'd2, 16'h7FFF, 16'h7FFF, 1, 1, 1, 1, 0, 0, 0, 0, "R9 add to fb");

        // R10 R11 section writes and top readout
        wr(2'd1, 16'h8001, "R10 mid fill");
        wr(2'd2, 16'h1234, "R10 R11 top write");
        wr(2'd2, 16'h0080, "R11 negative top");
        wr(2'd3, 16'hFFFF, "R10 ignored select");
        wr(2'd0, 16'hABCD, "R10 low only");

        // R12 concurrent write and operation
        step(3'd2, 16'h4000, 16'h4000, 1, 1, 1, 0, 0, 1, 2'd0, 16'h5555, "R12 add with low write");
        step(3'd6, 0, 0, 0, 0, 0, 1, 0, 1, 2'd1, 16'h7000, "R12 round fb with mid write");
        step(3'd4, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'h00FF, "R12 clear with top write");
        step(3'd1, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 1, 2'd3, 16'h0000, "R12 load with null write");

        // R5 mixed stream
        for (int i = 0; i < 400; i++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            step(o, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom_range(0, 3) == 0), 1'($urandom),
                 ($urandom_range(0, 4) == 0), 2'($urandom), 16'($urandom),
                 "R5 R4 mixed stream");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule